// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter of a parallel NOR flash with a 16-bit word address and a 16-bit data path. The host's bus write cycles reach it as one-clock strobes, each carrying an address and a data word. Every operation that alters the array is guarded by a two-write unlock prefix. Erase operations repeat that prefix, so an erase takes six writes. When a guarded sequence completes, the block issues a one-cycle request for a word program, a sector erase or a whole-array erase. The request carries the captured address, sector number and data. The same prefix also switches an identification-mode flag on or off.

The array, the program and erase timers and all pin-level timing sit outside this block. The program/erase timer drives a `busy` input. While `busy` is high, every write strobe is ignored and the sequence position is held.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears `id_mode` and all requests and abandons any partly entered sequence. A later write that would have completed that sequence produces no request.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, followed by a fourth write (W_addr, W_data), raise `prog_req` for exactly one cycle. That cycle follows the clock edge that samples the fourth strobe, with `req_addr`=W_addr and `req_data`=W_data.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h raise `erase_chip_req` for one cycle.
- R4: The same first five writes followed by 30h at any address raise `erase_sec_req` for one cycle. `req_sector` is address bits 15..11 of that sixth write, giving 32 sectors of 2K words, and `req_addr` is its full address.
- R5: Command matching compares only address bits 14..0 and data bits 7..0. Address bit 15 and data bits 15..8 have no effect on matching.
- R6: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set `id_mode` in the cycle after the third strobe.
- R7: `id_mode` is cleared by a single write with data F0h at any address while no sequence is in progress. It is also cleared by AAh@5555h, 55h@2AAAh, F0h@5555h.
- R8: A write that does not match the expected next step returns the decoder to idle and issues nothing. The write is not reinterpreted as a first step, and the steps that follow it are then ignored.
- R9: While `busy` is high, writes have no effect. No request is issued, `id_mode` does not change (even for F0h), and the sequence position is kept for when `busy` falls.
- R10: At most one of the three request outputs is high in any cycle, and no request lasts more than one cycle.
- R11: In the sixth erase step, 10h at an address other than 5555h (bits 14..0) issues no request.
- R12: Address and data values present while `wr_stb` is low have no effect on the sequence position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| busy | input | 1 | Program/erase timer running |
| prog_req | output | 1 | Word program request pulse |
| erase_sec_req | output | 1 | Sector erase request pulse |
| erase_chip_req | output | 1 | Whole-array erase request pulse |
| req_addr | output | 16 | Captured address of the requesting write |
| req_sector | output | 5 | Sector number (address bits 15..11) |
| req_data | output | 16 | Captured data of the requesting write |
| id_mode | output | 1 | Identification mode active |

## Verification
The hardest state to reach from the ports is a sequence partly entered, then interrupted by writes during `busy` or by strobe-less bus activity, and then resumed. The bench enters the unlock prefix and raises `busy` for a junk write. It then lowers `busy` and finishes the sequence, expecting the request to fire. It does the same with address and data changing while the strobe is low. Aborts are swept by corrupting each step position of the program and erase sequences in turn. The bench then checks that the remaining steps neither issue a request nor restart a sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_PROG,
    ST_E3,
    ST_E4,
    ST_E5
  } seq_st_t;

  // compared address width and the two unlock keys
  localparam int KEY_AW = 15;
  localparam int NKEY   = 2;
  localparam logic [KEY_AW-1:0] ADDR_KEYS [NKEY] = '{15'h5555, 15'h2AAA};

  // command codes compared on the low data byte
  localparam int CMD_W = 8;
  localparam int NCODE = 8;
  localparam logic [CMD_W-1:0] CODES [NCODE] = '{
    8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10, 8'h30, 8'h90, 8'hF0
  };

  typedef struct packed {
    logic at_a;
    logic at_b;
    logic d_unlk1;
    logic d_unlk2;
    logic d_prog;
    logic d_erase;
    logic d_chip;
    logic d_sect;
    logic d_idon;
    logic d_idoff;
  } hit_t;

  typedef struct packed {
    logic prog;
    logic sect;
    logic chip;
    logic id_on;
    logic id_off;
  } evt_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output hit_t              hit
);
  logic [NKEY-1:0]  ahit;
  logic [NCODE-1:0] dhit;

  for (genvar k = 0; k < NKEY; k++) begin : g_akey
    assign ahit[k] = (addr[KEY_AW-1:0] == ADDR_KEYS[k]);
  end

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    assign dhit[c] = (data[CMD_W-1:0] == CODES[c]);
  end

  always_comb begin
    hit.at_a    = ahit[0];
    hit.at_b    = ahit[1];
    hit.d_unlk1 = dhit[0];
    hit.d_unlk2 = dhit[1];
    hit.d_prog  = dhit[2];
    hit.d_erase = dhit[3];
    hit.d_chip  = dhit[4];
    hit.d_sect  = dhit[5];
    hit.d_idon  = dhit[6];
    hit.d_idoff = dhit[7];
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stb,
  input  logic    busy,
  input  hit_t    hit,
  output evt_t    evt
);
  seq_st_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    evt    = '0;
    if (stb && !busy) begin
      st_nxt = ST_IDLE;
      unique case (st)
        ST_IDLE: begin
          if (hit.at_a && hit.d_unlk1) st_nxt = ST_K1;
          else if (hit.d_idoff)        evt.id_off = 1'b1;
        end
        ST_K1: if (hit.at_b && hit.d_unlk2) st_nxt = ST_K2;
        ST_K2: begin
          if (hit.at_a) begin
            if (hit.d_prog)       st_nxt = ST_PROG;
            else if (hit.d_erase) st_nxt = ST_E3;
            else if (hit.d_idon)  evt.id_on = 1'b1;
            else if (hit.d_idoff) evt.id_off = 1'b1;
          end
        end
        ST_PROG: evt.prog = 1'b1;
        ST_E3: if (hit.at_a && hit.d_unlk1) st_nxt = ST_E4;
        ST_E4: if (hit.at_b && hit.d_unlk2) st_nxt = ST_E5;
        ST_E5: begin
          if (hit.at_a && hit.d_chip) evt.chip = 1'b1;
          else if (hit.d_sect)        evt.sect = 1'b1;
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/fcd_outreg.sv
module fcd_outreg
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  evt_t              evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              prog_req,
  output logic              erase_sec_req,
  output logic              erase_chip_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SECT_W-1:0] req_sector,
  output logic [DATA_W-1:0] req_data,
  output logic              id_mode
);
  logic any_req;
  assign any_req = evt.prog | evt.sect | evt.chip;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_req       <= 1'b0;
      erase_sec_req  <= 1'b0;
      erase_chip_req <= 1'b0;
      id_mode        <= 1'b0;
    end else begin
      prog_req       <= evt.prog;
      erase_sec_req  <= evt.sect;
      erase_chip_req <= evt.chip;
      if (evt.id_on)       id_mode <= 1'b1;
      else if (evt.id_off) id_mode <= 1'b0;
    end
  end

  // payload registers need no reset: qualified by the pulses
  always_ff @(posedge clk) begin
    if (any_req) begin
      req_addr   <= addr;
      req_sector <= addr[ADDR_W-1 -: SECT_W];
      req_data   <= data;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int SECTOR_WORDS = 2048,
  localparam int SECT_W      = ADDR_W - $clog2(SECTOR_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prog_req,
  output logic              erase_sec_req,
  output logic              erase_chip_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SECT_W-1:0] req_sector,
  output logic [DATA_W-1:0] req_data,
  output logic              id_mode
);
  hit_t hit;
  evt_t evt;

  fcd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr(wr_addr), .data(wr_data), .hit(hit)
  );

  fcd_seq u_seq (
    .clk(clk), .rst(rst), .stb(wr_stb), .busy(busy), .hit(hit), .evt(evt)
  );

  fcd_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_out (
    .clk(clk), .rst(rst), .evt(evt), .addr(wr_addr), .data(wr_data),
    .prog_req(prog_req), .erase_sec_req(erase_sec_req),
    .erase_chip_req(erase_chip_req), .req_addr(req_addr),
    .req_sector(req_sector), .req_data(req_data), .id_mode(id_mode)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int SECT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              prog_req,
  input logic              erase_sec_req,
  input logic              erase_chip_req,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SECT_W-1:0] req_sector,
  input logic [DATA_W-1:0] req_data,
  input logic              id_mode
);
  logic any_req;
  assign any_req = prog_req | erase_sec_req | erase_chip_req;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !id_mode && !any_req);

  a_r2_prog_payload: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> $past(wr_stb && !busy) && req_addr == $past(wr_addr)
                 && req_data == $past(wr_data));

  a_r4_sector_index: assert property (@(posedge clk) disable iff (rst)
    erase_sec_req |-> req_sector == $past(wr_addr[ADDR_W-1 -: SECT_W])
                      && $past(wr_data[7:0]) == 8'h30);

  a_r3_chip_code: assert property (@(posedge clk) disable iff (rst)
    erase_chip_req |-> $past(wr_data[7:0]) == 8'h10
                       && $past(wr_addr[14:0]) == 15'h5555);

  a_r6_id_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> $past(wr_stb && !busy) && $past(wr_data[7:0]) == 8'h90);

  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_stb) |=> !any_req && $stable(id_mode));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, erase_sec_req, erase_chip_req}));

  a_r10_single_cycle: assert property (@(posedge clk) disable iff (rst)
    any_req |=> !any_req);
endmodule

bind flash_cmd_decoder fcd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .prog_req(prog_req),
  .erase_sec_req(erase_sec_req), .erase_chip_req(erase_chip_req),
  .req_addr(req_addr), .req_sector(req_sector), .req_data(req_data),
  .id_mode(id_mode)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        prog_req, erase_sec_req, erase_chip_req, id_mode;
  logic [15:0] req_addr, req_data;
  logic [4:0]  req_sector;

  int n_chk = 0;
  int n_bad = 0;

  // 20 time-unit period: 50 MHz with a 1 ns unit
  always #10 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .prog_req(prog_req),
    .erase_sec_req(erase_sec_req), .erase_chip_req(erase_chip_req),
    .req_addr(req_addr), .req_sector(req_sector), .req_data(req_data),
    .id_mode(id_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // kind: {prog, sect, chip}; checked right after the final write
  task automatic expect_req(input string tag, input logic [2:0] kind,
                            input logic [15:0] a, input logic [15:0] d);
    chk(tag, {29'd0, prog_req, erase_sec_req, erase_chip_req}, {29'd0, kind});
    if (kind != 3'b000) begin
      chk(tag, {16'd0, req_addr}, {16'd0, a});
      if (kind == 3'b010) chk(tag, {27'd0, req_sector}, {27'd0, a[15:11]});
      else                chk(tag, {16'd0, req_data}, {16'd0, d});
    end
    @(negedge clk);
    chk({tag, " pulse width (R10)"},
        {29'd0, prog_req, erase_sec_req, erase_chip_req}, 32'd0);
  endtask

  function automatic logic [15:0] ers_a(input int p, input logic [15:0] sa);
    case (p)
      0, 2, 3: return 16'h5555;
      1, 4:    return 16'h2AAA;
      default: return sa;
    endcase
  endfunction

  function automatic logic [15:0] ers_d(input int p);
    case (p)
      0, 3:    return 16'h00AA;
      1, 4:    return 16'h0055;
      2:       return 16'h0080;
      default: return 16'h0030;
    endcase
  endfunction

  task automatic prog_seq(input logic [15:0] a, input logic [15:0] d);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    wr(a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 id_mode after reset", {31'd0, id_mode}, 32'd0);
    chk("R1 requests after reset", {29'd0, prog_req, erase_sec_req, erase_chip_req}, 32'd0);

    // R2 program sweep over addresses and data
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a, d;
      a = 16'(i * 16'h1111) ^ 16'h0A5C;
      d = ~a ^ 16'(i << 4);
      prog_seq(a, d);
      expect_req("R2 program", 3'b100, a, d);
    end

    // R5 bit 15 and upper data byte ignored in matching
    wr(16'hD555, 16'h5AAA); wr(16'hAAAA, 16'hC355); wr(16'hD555, 16'h77A0);
    wr(16'h8001, 16'hBEEF);
    expect_req("R5 masked bits", 3'b100, 16'h8001, 16'hBEEF);

    // R4 sector erase sweep over all 32 sectors
    for (int s = 0; s < 32; s++) begin
      logic [15:0] sa;
      sa = {5'(s), 11'(s * 73 + 5)};
      for (int p = 0; p < 6; p++) wr(ers_a(p, sa), ers_d(p));
      expect_req("R4 sector erase", 3'b010, sa, 16'h0030);
    end

    // R3 chip erase, also with upper bits set (R5)
    for (int p = 0; p < 5; p++) wr(ers_a(p, 0), ers_d(p));
    wr(16'h5555, 16'h0010);
    expect_req("R3 chip erase", 3'b001, 16'h5555, 16'h0010);
    for (int p = 0; p < 5; p++) wr(ers_a(p, 0) | 16'h8000, ers_d(p) | 16'hFF00);
    wr(16'hD555, 16'h3310);
    expect_req("R3 chip erase masked", 3'b001, 16'hD555, 16'h3310);

    // R11 chip code at wrong address
    for (int p = 0; p < 5; p++) wr(ers_a(p, 0), ers_d(p));
    wr(16'h1234, 16'h0010);
    expect_req("R11 chip code off key", 3'b000, 0, 0);

    // R6 / R7 identification mode
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    chk("R6 id entry", {31'd0, id_mode}, 32'd1);
    wr(16'h1234, 16'h00F0);
    chk("R7 single-write exit", {31'd0, id_mode}, 32'd0);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    chk("R6 id re-entry", {31'd0, id_mode}, 32'd1);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055);
    chk("R7 still set mid exit", {31'd0, id_mode}, 32'd1);
    wr(16'h5555, 16'h00F0);
    chk("R7 three-write exit", {31'd0, id_mode}, 32'd0);

    // R8 abort at each program step
    for (int p = 0; p < 3; p++) begin
      logic [15:0] sa [3];
      logic [15:0] sd [3];
      sa = '{16'h5555, 16'h2AAA, 16'h5555};
      sd = '{16'h00AA, 16'h0055, 16'h00A0};
      sd[p] = sd[p] ^ 16'h0001;
      for (int q = 0; q < 3; q++) wr(sa[q], sd[q]);
      wr(16'h0321, 16'h1234);
      expect_req("R8 program abort", 3'b000, 0, 0);
    end
    // R8 abort at each erase step before the last
    for (int p = 0; p < 5; p++) begin
      for (int q = 0; q < 6; q++)
        wr(ers_a(q, 16'h4800), (q == p) ? (ers_d(q) ^ 16'h0001) : ers_d(q));
      expect_req("R8 erase abort", 3'b000, 0, 0);
    end
    prog_seq(16'h0042, 16'h4242);
    expect_req("R8 recovers after abort", 3'b100, 16'h0042, 16'h4242);

    // R9 busy: whole sequence ignored
    busy = 1'b1;
    prog_seq(16'h0100, 16'h0200);
    expect_req("R9 busy program", 3'b000, 0, 0);
    busy = 1'b0;
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    busy = 1'b1;
    wr(16'h0000, 16'h00F0);
    chk("R9 busy blocks exit", {31'd0, id_mode}, 32'd1);
    busy = 1'b0;
    wr(16'h0000, 16'h00F0);
    chk("R9 exit after busy", {31'd0, id_mode}, 32'd0);
    // R9 position held across busy writes
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055);
    busy = 1'b1;
    wr(16'h7777, 16'h0001);
    busy = 1'b0;
    wr(16'h5555, 16'h00A0); wr(16'h0F0F, 16'hCAFE);
    expect_req("R9 position held", 3'b100, 16'h0F0F, 16'hCAFE);

    // R12 bus activity without strobe
    wr(16'h5555, 16'h00AA);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wr_addr = 16'(k * 16'h3C3C); wr_data = 16'(k * 16'h0F11);
    end
    wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(16'h1357, 16'h2468);
    expect_req("R12 no strobe no effect", 3'b100, 16'h1357, 16'h2468);

    // R1 reset mid-sequence and clearing id_mode
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears id_mode", {31'd0, id_mode}, 32'd0);
    wr(16'h0AAA, 16'h5555);
    expect_req("R1 sequence dropped by reset", 3'b000, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule